// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Logic

This block sits between a motor controller's six PWM commands and the six gate enables of a three-phase half-bridge inverter. Each phase has a high-side and a low-side command. The block passes a command to its gate only when it is safe to do so. It refuses any phase whose two commands are both high, so the two switches of a leg can never conduct together.

Five asynchronous supervision flags come in from analog comparators: an overcurrent trip, a main-supply undervoltage and one high-side supply undervoltage per phase. Each flag is resynchronised through a chain of flip-flops.

- An overcurrent trip shuts every gate and pulls the active-low open-drain fault line. The fault then releases itself after a programmable clearance time, and that time restarts if the trip returns.
- A main-supply undervoltage shuts every gate without raising the fault. Operation resumes as soon as the supply is good.
- A high-side undervoltage shuts only the upper gate of its own phase. That gate stays off after the supply recovers, until the controller has driven its command low once.

Top module: `gate_guard`

## Requirements
- R1: A high-side gate is on one clock after its phase is commanded high-side 1 and low-side 0, provided no protection is active.
- R2: A low-side gate is on one clock after its phase is commanded low-side 1 and high-side 0. With both commands 0, both gates of that phase are off.
- R3: A phase commanded with both inputs high has both of its gates off. Other phases are not affected.
- R4: The high and low gates of one phase are never on in the same cycle.
- R5: The overcurrent flag takes effect three clocks after it is raised at the pin. At that point all six gates are off and both fault_pull and fault_sts are 1.
- R6: While fault_sts is 1, all six gates are off whatever the commands.
- R7: Once the overcurrent pin drops, the fault clears exactly CLR_CYCLES+2 clocks later, and the gates follow one clock after that. Raising the pin again during the countdown restarts it.
- R8: A main-supply undervoltage turns all gates off three clocks after the pin rises and does not assert the fault. The gates resume three clocks after the pin falls, with no timer.
- R9: A high-side undervoltage on one phase turns off that phase's upper gate three clocks after the pin rises. Lower gates and the other phases are not affected.
- R10: After its high-side undervoltage recovers, an upper gate stays off for as long as its command remains high. It is released only after the command has been sampled low.
- R11: During reset all gates are off and fault_pull and fault_sts are 0.
- R12: A command change never reaches the gates in the same cycle; it appears after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_cmd | input | N_PHASE | High-side PWM commands, bit i = phase i |
| lo_cmd | input | N_PHASE | Low-side PWM commands, bit i = phase i |
| oc_flag | input | 1 | Overcurrent comparator output, asynchronous, 1 = trip |
| vdd_uv | input | 1 | Main-supply undervoltage, asynchronous, 1 = low supply |
| hs_uv | input | N_PHASE | Per-phase high-side supply undervoltage, asynchronous |
| gate_hi | output | N_PHASE | Upper gate enables |
| gate_lo | output | N_PHASE | Lower gate enables |
| fault_pull | output | 1 | 1 = pull the open-drain fault line low |
| fault_sts | output | 1 | Registered fault status |

## Verification
The per-phase truth table is tried with mixed vectors in which the phases carry different command pairs at once. This separates a shoot-through block applied to a single leg from one applied to the whole bridge, and it catches swapped high and low paths.

Overcurrent is held, released and re-raised mid-countdown, with the fault sampled on both sides of its exact clearing edge. This tells an off-by-one in the timer from a timer that does not restart.

Main-supply undervoltage is checked against the fault output to show that it is not latched and raises no fault. High-side undervoltage is applied to one phase while another stays commanded, which separates per-phase masking from a global one. It also shows that the upper gate waits for its command to go low before it is released.

// File: rtl/gate_guard_pkg.sv
`timescale 1ns/1ps
package gate_guard_pkg;

    // Registered state of one inverter leg
    typedef struct packed {
        logic hi;    // upper gate enable
        logic lo;    // lower gate enable
        logic lock;  // upper gate held off after high-side undervoltage
    } leg_state_t;

    typedef enum logic {
        FLT_RUN  = 1'b0,
        FLT_HOLD = 1'b1
    } flt_mode_t;

endpackage

// File: rtl/gg_flag_sync.sv
`timescale 1ns/1ps
module gg_flag_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            sh_d[k] = sh_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/gg_fault_timer.sv
`timescale 1ns/1ps
module gg_fault_timer
    import gate_guard_pkg::*;
#(
    parameter int CLR_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_s,
    output logic fault
);
    localparam int              CW   = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0]   LAST = CW'(CLR_CYCLES - 1);

    typedef struct packed {
        flt_mode_t     mode;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (oc_s) begin
            // trip present: hold and restart the clearance count
            st_d.mode = FLT_HOLD;
            st_d.cnt  = '0;
        end else if (st_q.mode == FLT_HOLD) begin
            if (st_q.cnt == LAST) begin
                st_d.mode = FLT_RUN;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: FLT_RUN, cnt: '0};
        else        st_q <= st_d;
    end

    assign fault = (st_q.mode == FLT_HOLD);
endmodule

// File: rtl/gg_phase_leg.sv
`timescale 1ns/1ps
module gg_phase_leg
    import gate_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic block_all,
    input  logic hs_uv_s,
    output logic gate_hi,
    output logic gate_lo
);
    leg_state_t st_d, st_q;
    logic       want_hi, want_lo;

    always_comb begin
        // exclusive decode: both-high gives neither
        want_hi = hi_cmd & ~lo_cmd;
        want_lo = lo_cmd & ~hi_cmd;
        // lock is set by undervoltage and released only once the command is low
        st_d.lock = hs_uv_s | (st_q.lock & hi_cmd);
        st_d.hi   = want_hi & ~block_all & ~hs_uv_s & ~st_q.lock;
        st_d.lo   = want_lo & ~block_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hi: 1'b0, lo: 1'b0, lock: 1'b0};
        else        st_q <= st_d;
    end

    assign gate_hi = st_q.hi;
    assign gate_lo = st_q.lo;
endmodule

// File: rtl/gate_guard.sv
`timescale 1ns/1ps
module gate_guard #(
    parameter int N_PHASE     = 3,
    parameter int CLR_CYCLES  = 2_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hi_cmd,
    input  logic [N_PHASE-1:0] lo_cmd,
    input  logic               oc_flag,
    input  logic               vdd_uv,
    input  logic [N_PHASE-1:0] hs_uv,
    output logic [N_PHASE-1:0] gate_hi,
    output logic [N_PHASE-1:0] gate_lo,
    output logic               fault_pull,
    output logic               fault_sts
);
    localparam int FW = N_PHASE + 2;

    logic [FW-1:0]      flags_s;
    logic               oc_s, vdd_s, fault_q, block_all;
    logic [N_PHASE-1:0] hs_s;

    gg_flag_sync #(.W(FW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hs_uv, vdd_uv, oc_flag}),
        .dout  (flags_s)
    );

    assign oc_s  = flags_s[0];
    assign vdd_s = flags_s[1];
    assign hs_s  = flags_s[FW-1:2];

    gg_fault_timer #(.CLR_CYCLES(CLR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .oc_s  (oc_s),
        .fault (fault_q)
    );

    // the raw synchronised trip is included so that gates drop on the same edge the fault rises
    assign block_all = fault_q | oc_s | vdd_s;

    for (genvar g = 0; g < N_PHASE; g++) begin : g_leg
        gg_phase_leg u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .hi_cmd    (hi_cmd[g]),
            .lo_cmd    (lo_cmd[g]),
            .block_all (block_all),
            .hs_uv_s   (hs_s[g]),
            .gate_hi   (gate_hi[g]),
            .gate_lo   (gate_lo[g])
        );
    end

    assign fault_pull = fault_q;
    assign fault_sts  = fault_q;
endmodule

// File: rtl/gate_guard_chk.sv
`timescale 1ns/1ps
module gate_guard_chk #(
    parameter int N_PHASE = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] hi_cmd,
    input logic [N_PHASE-1:0] lo_cmd,
    input logic               oc_flag,
    input logic               vdd_uv,
    input logic [N_PHASE-1:0] hs_uv,
    input logic [N_PHASE-1:0] gate_hi,
    input logic [N_PHASE-1:0] gate_lo,
    input logic               fault_pull,
    input logic               fault_sts
);
    // counts edges since reset so that 3-deep history is valid
    logic [1:0] warm_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    assign ready = (warm_q == 2'd3);

    p_hi_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & ~($past(hi_cmd) & ~$past(lo_cmd))) == '0);

    p_lo_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lo & ~($past(lo_cmd) & ~$past(hi_cmd))) == '0);

    p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    p_oc_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(oc_flag, 3)) |-> (fault_pull && fault_sts && gate_hi == '0 && gate_lo == '0));

    p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sts |-> (gate_hi == '0 && gate_lo == '0));

    p_clear_after_oc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $fell(fault_sts)) |-> !$past(oc_flag, 3));

    p_uv_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(vdd_uv, 3)) |-> (gate_hi == '0 && gate_lo == '0));

    p_hs_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((gate_hi & $past(hs_uv, 3)) == '0));
endmodule

bind gate_guard gate_guard_chk #(.N_PHASE(N_PHASE)) u_chk (.*);

// File: tb/gate_guard_tb.sv
`timescale 1ns/1ps
module gate_guard_tb;
    localparam int CLR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hi_cmd = '0, lo_cmd = '0, hs_uv = '0;
    logic       oc_flag = 1'b0, vdd_uv = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic       fault_pull, fault_sts;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    gate_guard #(.N_PHASE(3), .CLR_CYCLES(CLR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .oc_flag(oc_flag), .vdd_uv(vdd_uv), .hs_uv(hs_uv),
        .gate_hi(gate_hi), .gate_lo(gate_lo),
        .fault_pull(fault_pull), .fault_sts(fault_sts)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_gates(input string tag, input logic [2:0] eh, input logic [2:0] el);
        chk({tag, " hi"}, {5'b0, gate_hi}, {5'b0, eh});
        chk({tag, " lo"}, {5'b0, gate_lo}, {5'b0, el});
    endtask

    task automatic t_reset;
        hi_cmd = 3'b001;
        tick(2);
        chk_gates("R11 reset gates", 3'b000, 3'b000);
        chk("R11 reset fault", {6'b0, fault_pull, fault_sts}, 8'h0);
        rst_n = 1'b1;
        tick(1);
        chk_gates("R1 after reset", 3'b001, 3'b000);
    endtask

    task automatic t_truth;
        hi_cmd = 3'b101; lo_cmd = 3'b010;
        #1 chk_gates("R12 no same-cycle change", 3'b001, 3'b000);
        tick(1);
        chk_gates("R1 R2 mixed", 3'b101, 3'b010);
        hi_cmd = 3'b011; lo_cmd = 3'b110;
        tick(1);
        chk_gates("R3 phase1 both high", 3'b001, 3'b100);
        hi_cmd = 3'b111; lo_cmd = 3'b111;
        tick(1);
        chk_gates("R3 all both high", 3'b000, 3'b000);
        hi_cmd = 3'b000; lo_cmd = 3'b000;
        tick(1);
        chk_gates("R2 all zero", 3'b000, 3'b000);
    endtask

    task automatic t_oc;
        hi_cmd = 3'b001; lo_cmd = 3'b100;
        tick(1);
        oc_flag = 1'b1;
        tick(2);
        chk_gates("R5 sync latency", 3'b001, 3'b100);
        tick(1);
        chk_gates("R5 trip gates", 3'b000, 3'b000);
        chk("R5 trip fault", {6'b0, fault_pull, fault_sts}, 8'h3);
        hi_cmd = 3'b010; lo_cmd = 3'b001;
        tick(4);
        chk_gates("R6 held off", 3'b000, 3'b000);
        oc_flag = 1'b0;
        tick(CLR + 1);
        chk("R7 still faulted", {7'b0, fault_sts}, 8'h1);
        tick(1);
        chk("R7 cleared", {7'b0, fault_pull}, 8'h0);
        chk_gates("R7 gates lag", 3'b000, 3'b000);
        tick(1);
        chk_gates("R7 resumed", 3'b010, 3'b001);
        // restart during countdown
        oc_flag = 1'b1;
        tick(4);
        oc_flag = 1'b0;
        tick(20);
        oc_flag = 1'b1;
        tick(2);
        oc_flag = 1'b0;
        tick(CLR + 1);
        chk("R7 restart held", {7'b0, fault_sts}, 8'h1);
        tick(1);
        chk("R7 restart cleared", {7'b0, fault_sts}, 8'h0);
        tick(1);
    endtask

    task automatic t_vdd;
        hi_cmd = 3'b100; lo_cmd = 3'b011;
        tick(1);
        vdd_uv = 1'b1;
        tick(3);
        chk_gates("R8 uv off", 3'b000, 3'b000);
        chk("R8 no fault", {6'b0, fault_pull, fault_sts}, 8'h0);
        vdd_uv = 1'b0;
        tick(2);
        chk_gates("R8 still off", 3'b000, 3'b000);
        tick(1);
        chk_gates("R8 resumed", 3'b100, 3'b011);
    endtask

    task automatic t_hs;
        hi_cmd = 3'b101; lo_cmd = 3'b010; hs_uv = 3'b100;
        tick(3);
        chk_gates("R9 phase2 only", 3'b001, 3'b010);
        hs_uv = 3'b000;
        tick(5);
        chk_gates("R10 held after recovery", 3'b001, 3'b010);
        hi_cmd = 3'b001;
        tick(1);
        hi_cmd = 3'b101;
        tick(1);
        chk_gates("R10 released", 3'b101, 3'b010);
    endtask

    initial begin
        t_reset();
        t_truth();
        t_oc();
        t_vdd();
        t_hs();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule